// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block paces the conversions of an on-chip temperature sensor and stores each finished reading. A free-running timing tick is counted to give every conversion a length set by the selected resolution: the finer the resolution, the longer the conversion. When a conversion ends, the raw 12-bit sample from the converter model is captured. Its low-order bits below the selected resolution are forced to zero, and the result is written to the temperature word. A one-cycle done strobe marks each update.

Three operating modes follow from two configuration inputs and a write strobe. With the shutdown bit clear, the block converts back to back without a break. With the shutdown bit set, it finishes the conversion already in flight and then powers down. While powered down, a one-shot write runs a single conversion, after which the block powers down again. A one-shot write that arrives while the block is converting continuously has no effect. The resolution code is sampled when a conversion starts, so one code governs both the duration of that conversion and the mask applied to its result.

Top module: `tsense_conv_ctrl`

## Requirements
- R1: After reset the temperature word is 0, the done strobe is low, the powered-down flag is low, and a conversion at resolution code 0 is in progress.
- R2: A conversion lasts UNIT_TICKS × 2^code clock cycles in which `tick` is high, where `code` is the resolution input sampled at the start of the conversion. With the default UNIT_TICKS=1, codes 0, 1, 2 and 3 take 1, 2, 4 and 8 ticks. Cycles without a tick do not advance the conversion.
- R3: Resolution code c (0 to 3) gives 9+c valid bits. The stored word equals the raw sample with its lowest 3−c bits cleared.
- R4: `conv_done` is high for one clock cycle. It rises in the cycle that follows the clock edge on which the final tick of a conversion was sampled. The temperature word takes its new value on that same edge.
- R5: While the shutdown input is 0, a new conversion starts on the edge that completes the previous one. Back-to-back results are therefore spaced by exactly one conversion length.
- R6: When the shutdown input is 1 at the edge that completes a conversion, that result is still stored. `powered_down` rises together with `conv_done`, and no further result is produced while the block stays powered down.
- R7: While powered down, a one-shot write pulse starts exactly one conversion. `powered_down` drops on the next edge and rises again with that conversion's done strobe.
- R8: A one-shot write while converting with the shutdown input at 0 is ignored: the spacing of done strobes does not change.
- R9: A change of the resolution input during a conversion does not alter that conversion. It applies from the next conversion onward.
- R10: The temperature word holds its value in every cycle in which `conv_done` is low.
- R11: Clearing the shutdown input while powered down resumes continuous conversion, starting on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sd | input | 1 | Shutdown request (1 = stop after the current conversion) |
| cfg_res | input | 2 | Resolution code, 0 = 9 bits up to 3 = 12 bits |
| oneshot_wr | input | 1 | One-cycle strobe: a one-shot bit was written |
| tick | input | 1 | Timing tick that advances the conversion |
| raw_sample | input | 12 | Raw reading from the converter model |
| temp_word | output | 12 | Stored, masked temperature result |
| conv_done | output | 1 | One-cycle strobe when a new result is stored |
| powered_down | output | 1 | High while no conversion is running |

## Verification
Two pairs of events can fall on the same clock edge: the end of a conversion and the shutdown decision, and the end of a conversion and a change of the resolution code. The bench raises the shutdown request partway through a conversion. It then checks that this conversion still completes on time and that the powered-down flag rises in the very cycle of its done strobe. The bench also changes the resolution code partway through a conversion and measures two intervals: the current interval must keep the old length, and the next one must take the new length.

// File: rtl/tsense_conv_pkg.sv
package tsense_conv_pkg;
   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_SLEEP = 1'b1
   } seq_state_e;
endpackage

// File: rtl/tsense_conv_timer.sv
module tsense_conv_timer #(
   parameter int UNIT_TICKS = 1,
   parameter int RES_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [RES_W-1:0] res,
   output logic             last
);
   localparam int NUM_RES   = 1 << RES_W;
   localparam int MAX_TICKS = UNIT_TICKS << (NUM_RES - 1);
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);
   localparam logic [CNT_W-1:0] UNIT_C = CNT_W'(UNIT_TICKS);

   if (UNIT_TICKS < 1) begin : g_bad_unit
      $error("UNIT_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;

   always_comb begin
      target = UNIT_C << res;
      last   = run && tick && (cnt_q == target - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         if (last) cnt_q <= '0;
         else      cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/tsense_res_mask.sv
module tsense_res_mask #(
   parameter int DATA_W = 12,
   parameter int RES_W  = 2
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [RES_W-1:0]  res,
   output logic [DATA_W-1:0] masked
);
   localparam int NUM_RES  = 1 << RES_W;
   localparam int DROP_MAX = NUM_RES - 1;

   if (DATA_W <= DROP_MAX) begin : g_bad_width
      $error("DATA_W must exceed the largest number of dropped bits");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i >= DROP_MAX) begin : g_keep
         assign masked[i] = raw[i];
      end else begin : g_cond
         assign masked[i] = raw[i] & (res >= RES_W'(DROP_MAX - i));
      end
   end
endmodule

// File: rtl/tsense_conv_fsm.sv
module tsense_conv_fsm
   import tsense_conv_pkg::*;
#(
   parameter int RES_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_sd,
   input  logic [RES_W-1:0] cfg_res,
   input  logic             oneshot_wr,
   input  logic             last,
   output logic             running,
   output logic [RES_W-1:0] res_q
);
   seq_state_e state_q;

   assign running = (state_q == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         res_q   <= '0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (last) begin
                  res_q <= cfg_res;
                  if (cfg_sd) state_q <= ST_SLEEP;
               end
            end
            ST_SLEEP: begin
               if (oneshot_wr || !cfg_sd) begin
                  res_q   <= cfg_res;
                  state_q <= ST_RUN;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/tsense_conv_ctrl.sv
module tsense_conv_ctrl #(
   parameter int DATA_W     = 12,
   parameter int RES_W      = 2,
   parameter int UNIT_TICKS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sd,
   input  logic [RES_W-1:0]  cfg_res,
   input  logic              oneshot_wr,
   input  logic              tick,
   input  logic [DATA_W-1:0] raw_sample,
   output logic [DATA_W-1:0] temp_word,
   output logic              conv_done,
   output logic              powered_down
);
   logic             running;
   logic             last;
   logic [RES_W-1:0] conv_res;
   logic [DATA_W-1:0] masked;

   tsense_conv_fsm #(.RES_W(RES_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_sd     (cfg_sd),
      .cfg_res    (cfg_res),
      .oneshot_wr (oneshot_wr),
      .last       (last),
      .running    (running),
      .res_q      (conv_res)
   );

   tsense_conv_timer #(.UNIT_TICKS(UNIT_TICKS), .RES_W(RES_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .tick  (tick),
      .res   (conv_res),
      .last  (last)
   );

   tsense_res_mask #(.DATA_W(DATA_W), .RES_W(RES_W)) u_mask (
      .raw    (raw_sample),
      .res    (conv_res),
      .masked (masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_word <= '0;
         conv_done <= 1'b0;
      end else begin
         conv_done <= last;
         if (last) temp_word <= masked;
      end
   end

   assign powered_down = !running;
endmodule

// File: rtl/tsense_conv_ctrl_chk.sv
module tsense_conv_ctrl_chk #(
   parameter int DATA_W = 12,
   parameter int RES_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_sd,
   input logic              oneshot_wr,
   input logic              tick,
   input logic [RES_W-1:0]  conv_res,
   input logic [DATA_W-1:0] temp_word,
   input logic              conv_done,
   input logic              powered_down
);
   localparam int NUM_RES  = 1 << RES_W;
   localparam int DROP_MAX = NUM_RES - 1;

   logic [RES_W-1:0]  prev_res;
   logic [DATA_W-1:0] low_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_res <= '0;
      else        prev_res <= conv_res;
   end

   always_comb begin
      low_mask = (DATA_W'(1) << (DROP_MAX - int'(prev_res))) - DATA_W'(1);
   end

   // R2
   done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> $past(tick));

   // R3
   low_bits_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> ((temp_word & low_mask) == '0));

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |-> $stable(temp_word));

   // R6
   sleep_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(powered_down) |-> conv_done);

   // R6
   no_result_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (powered_down && !$rose(powered_down)) |-> !conv_done);

   // R7
   wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(powered_down) |-> $past(oneshot_wr || !cfg_sd));
endmodule

bind tsense_conv_ctrl tsense_conv_ctrl_chk #(.DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_sd       (cfg_sd),
   .oneshot_wr   (oneshot_wr),
   .tick         (tick),
   .conv_res     (conv_res),
   .temp_word    (temp_word),
   .conv_done    (conv_done),
   .powered_down (powered_down)
);

// File: tb/tsense_conv_ctrl_tb.sv
module tsense_conv_ctrl_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sd = 1'b1;
   logic [1:0]  cfg_res = 2'd0;
   logic        oneshot_wr = 1'b0;
   logic        tick = 1'b0;
   logic [11:0] raw_sample = 12'h123;
   logic [11:0] temp_word;
   logic        conv_done;
   logic        powered_down;

   int tests = 0;
   int fails = 0;

   always #(CLK_P/2) clk = ~clk;

   tsense_conv_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_sd(cfg_sd), .cfg_res(cfg_res),
      .oneshot_wr(oneshot_wr), .tick(tick), .raw_sample(raw_sample),
      .temp_word(temp_word), .conv_done(conv_done), .powered_down(powered_down)
   );

   // {res, raw, expected word, expected ticks}
   localparam logic [29:0] VEC [8] = '{
      {2'd0, 12'h7FF, 12'h7F8, 4'd1},
      {2'd1, 12'h7FF, 12'h7FC, 4'd2},
      {2'd2, 12'h7FF, 12'h7FE, 4'd4},
      {2'd3, 12'h7FF, 12'h7FF, 4'd8},
      {2'd0, 12'hE77, 12'hE70, 4'd1},
      {2'd3, 12'h004, 12'h004, 4'd8},
      {2'd1, 12'hC93, 12'hC90, 4'd2},
      {2'd2, 12'h195, 12'h194, 4'd4}
   };

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_done(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!conv_done && n < 200);
   endtask

   initial begin
      #(CLK_P*200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n;
      int cnt;
      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 word", int'(temp_word), 0);
      check("R1 done", int'(conv_done), 0);
      check("R1 pd", int'(powered_down), 0);
      // R1 first conversion at code 0, R6 sleep afterwards
      tick = 1'b1;
      @(negedge clk);
      check("R1 first done", int'(conv_done), 1);
      check("R3 first word", int'(temp_word), 12'h120);
      check("R6 pd with done", int'(powered_down), 1);

      // Table: one-shot conversions (R2, R3, R4, R7)
      for (int i = 0; i < 8; i++) begin
         cfg_res    = VEC[i][29:28];
         raw_sample = VEC[i][27:16];
         oneshot_wr = 1'b1;
         @(negedge clk);
         oneshot_wr = 1'b0;
         check("R7 awake", int'(powered_down), 0);
         wait_done(n);
         check("R2 ticks", n, int'(VEC[i][3:0]));
         check("R3 word", int'(temp_word), int'(VEC[i][15:4]));
         check("R7 back asleep", int'(powered_down), 1);
         @(negedge clk);
         check("R4 one cycle", int'(conv_done), 0);
      end

      // R2 gating and R10 hold
      tick = 1'b0; cfg_res = 2'd1; raw_sample = 12'hABC;
      oneshot_wr = 1'b1; @(negedge clk); oneshot_wr = 1'b0;
      cnt = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (conv_done) cnt++;
      end
      check("R2 no tick no done", cnt, 0);
      check("R10 word held", int'(temp_word), 12'h194);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      check("R2 one tick", int'(conv_done), 0);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      check("R2 two ticks", int'(conv_done), 1);
      check("R3 word gated", int'(temp_word), 12'hABC);
      tick = 1'b1;

      // R11 resume continuous
      cfg_res = 2'd0; cfg_sd = 1'b0;
      wait_done(n);
      check("R11 resume", n, 2);
      check("R11 pd low", int'(powered_down), 0);
      wait_done(n);
      check("R5 back to back", n, 1);

      // R9 resolution change mid conversion
      cfg_res = 2'd3;
      wait_done(n);
      wait_done(n);
      check("R5 spacing code3", n, 8);
      repeat (3) @(negedge clk);
      cfg_res = 2'd0;
      wait_done(n);
      check("R9 old length kept", n, 5);
      wait_done(n);
      check("R9 new length", n, 1);

      // R8 one-shot ignored while running
      cfg_res = 2'd1;
      wait_done(n);
      wait_done(n);
      check("R5 spacing code1", n, 2);
      oneshot_wr = 1'b1; @(negedge clk); oneshot_wr = 1'b0;
      wait_done(n);
      check("R8 spacing", n + 1, 2);
      check("R8 pd", int'(powered_down), 0);

      // R6 shutdown mid conversion
      cfg_res = 2'd3;
      wait_done(n);
      raw_sample = 12'h5A5;
      repeat (3) @(negedge clk);
      cfg_sd = 1'b1;
      check("R6 pd before end", int'(powered_down), 0);
      wait_done(n);
      check("R6 finishes", n, 5);
      check("R6 stored", int'(temp_word), 12'h5A5);
      check("R6 pd rises", int'(powered_down), 1);
      cnt = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (conv_done) cnt++;
      end
      check("R6 no more results", cnt, 0);
      check("R6 stays down", int'(powered_down), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule